// File: doc/BRIEF.md
# Display Pipeline Lock Bank

This block holds a bank of independent hardware locks that let software change the settings of a display pipeline without tearing a frame. Each lock slot has its own small register window with an enable, a lock request and status word, a clear strobe, a module membership mask and a frame-source select. Software enables a slot, lists the pipeline modules it owns, picks the display interface whose frame timing it follows, and then asks for the lock. It polls the grant bit, rewrites the pipeline settings, and writes the lock register again to let go.

A grant is never given in the same cycle as the request. In single mode (no frame source) it is given one clock later. With a frame source selected it waits for the next start-of-frame pulse from that interface. While a slot is locked, it raises a hold line for each module in its mask. After release, the hold stays up until the next frame boundary of the same source, so the modules pick up the new settings together.

Top module: `disp_mutex_bank`

## Requirements
- R1: There are NUM_INST (default 10) slots. Slot n has a 32-byte window at byte address 0x20 + 0x20*n, with registers at offsets 0x00 enable, 0x04 lock, 0x08 clear, 0x0C mask and 0x10 frame source. After reset every register reads 0 and `mod_hold` is 0. A write to one slot leaves every other slot unchanged.
- R2: Bit 0 of the enable register is written and read back as the slot's active flag.
- R3: Writing the lock register with bit 0 set requests the lock. On read, bit 0 shows that a request is pending or granted, and bit 1 shows the grant.
- R4: With frame source 0 (single mode), a pending request is granted on the clock edge after the one that stored it.
- R5: Frame source codes 1, 2 and 3 select `sof_pulse` bits 0, 1 and 2. A pending request is granted on the first clock edge at which the selected bit is high. Pulses on the other bits have no effect.
- R6: Writing the lock register with bit 0 clear drops both the request and the grant, and bit 1 reads 0 from the next cycle.
- R7: `mod_hold` bit m is high while any slot whose mask has bit m set is holding. A slot starts holding at its grant. It stops at the first edge after release where its source fires, which in single mode is the edge after release.
- R8: Writing the clear register with bit 0 set drops the slot's request and grant. Its enable, mask and source values are kept.
- R9: A lock request written while the slot is disabled is ignored. The status word stays 0 and no hold is raised.
- R10: The mask register stores and returns all NUM_MOD bits.
- R11: Reads of the clear register, of unused offsets, of misaligned addresses and of addresses outside all windows return 0. Writes to unused locations change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| sof_pulse | input | NUM_SRC | Start-of-frame pulse, one bit per display interface |
| mod_hold | output | NUM_MOD | Per-module hold, OR of all holding slots' masks |

## Verification
The assertions assume that `sof_pulse` bits are single-cycle strobes and that a slot's frame source is not rewritten while the slot holds. Under those assumptions, a grant or a hold drop can be traced back to the source pulse of the previous edge. The directed stimulus keeps to these assumptions. It raises each pulse for exactly one clock, and it sets the enable, mask and source of a slot before requesting its lock. It also releases every slot, and lets that slot's source fire, before a later scenario checks `mod_hold`.

// File: rtl/dmx_pkg.sv
// Shared encodings for the display lock bank.
// Assumes byte addressing with 32-byte windows per slot.
package dmx_pkg;
    localparam int WIN_SHIFT = 5;
    localparam int SRC_W     = 2;

    localparam logic [4:0] OFS_ENABLE = 5'h00;
    localparam logic [4:0] OFS_LOCK   = 5'h04;
    localparam logic [4:0] OFS_CLEAR  = 5'h08;
    localparam logic [4:0] OFS_MASK   = 5'h0C;
    localparam logic [4:0] OFS_SOURCE = 5'h10;

    typedef enum logic [2:0] {
        REG_ENABLE,
        REG_LOCK,
        REG_CLEAR,
        REG_MASK,
        REG_SOURCE,
        REG_NONE
    } reg_sel_e;
endpackage

// File: rtl/dmx_addr_dec.sv
// Address decoder: splits a byte address into a slot index and a register
// selector. Assumes window 0 is unused and slot n lives in window n+1.
module dmx_addr_dec
    import dmx_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_INST = 10,
    localparam int IDX_W   = $clog2(NUM_INST),
    localparam int WIN_W   = ADDR_W - WIN_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output reg_sel_e          sel
);
    logic [WIN_W-1:0] win;

    // Decode window number and register offset
    always_comb begin
        win = addr[ADDR_W-1:WIN_SHIFT];
        idx = IDX_W'(win - WIN_W'(1));
        case (addr[WIN_SHIFT-1:0])
            OFS_ENABLE: sel = REG_ENABLE;
            OFS_LOCK:   sel = REG_LOCK;
            OFS_CLEAR:  sel = REG_CLEAR;
            OFS_MASK:   sel = REG_MASK;
            OFS_SOURCE: sel = REG_SOURCE;
            default:    sel = REG_NONE;
        endcase
        hit = (sel != REG_NONE) && (win != '0) && (win <= WIN_W'(NUM_INST));
    end
endmodule

// File: rtl/dmx_slot.sv
// One lock slot: configuration registers, request/grant state and the
// frame-aligned hold flag. Assumes wr_en is already qualified by address.
module dmx_slot
    import dmx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_MOD = 32,
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  reg_sel_e           sel,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] sof_in,
    output logic               en,
    output logic               pend,
    output logic               granted,
    output logic               hold,
    output logic [NUM_MOD-1:0] mask,
    output logic [SRC_W-1:0]   src,
    output logic [DATA_W-1:0]  rd_word
);
    logic src_hit;
    logic lock_wr;
    logic clear_wr;
    logic grant_fire;

    // Select the frame pulse of the chosen source; single mode always fires
    always_comb begin
        src_hit = 1'b0;
        if (src == '0) begin
            src_hit = 1'b1;
        end else begin
            for (int k = 0; k < NUM_SRC; k++) begin
                if (int'(src) == k + 1) src_hit = sof_in[k];
            end
        end
    end

    // Qualify writes and decide whether a grant lands this edge
    always_comb begin
        lock_wr    = wr_en && (sel == REG_LOCK);
        clear_wr   = wr_en && (sel == REG_CLEAR) && wdata[0];
        grant_fire = pend && en && src_hit && !lock_wr && !clear_wr;
    end

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            mask <= '0;
            src  <= '0;
        end else if (wr_en) begin
            case (sel)
                REG_ENABLE: en   <= wdata[0];
                REG_MASK:   mask <= wdata[NUM_MOD-1:0];
                REG_SOURCE: src  <= wdata[SRC_W-1:0];
                default: ;
            endcase
        end
    end

    // Request and grant state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            granted <= 1'b0;
        end else if (clear_wr) begin
            pend    <= 1'b0;
            granted <= 1'b0;
        end else if (lock_wr) begin
            if (wdata[0]) begin
                if (en && !granted) pend <= 1'b1;
            end else begin
                pend    <= 1'b0;
                granted <= 1'b0;
            end
        end else if (grant_fire) begin
            granted <= 1'b1;
            pend    <= 1'b0;
        end
    end

    // Hold rises with the grant and falls at a source pulse once released
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= 1'b0;
        end else if (grant_fire) begin
            hold <= 1'b1;
        end else if (!granted && src_hit) begin
            hold <= 1'b0;
        end
    end

    // Readback word for the selected register
    always_comb begin
        rd_word = '0;
        case (sel)
            REG_ENABLE: rd_word[0] = en;
            REG_LOCK: begin
                rd_word[0] = pend | granted;
                rd_word[1] = granted;
            end
            REG_MASK:   rd_word = DATA_W'(mask);
            REG_SOURCE: rd_word = DATA_W'(src);
            default:    rd_word = '0;
        endcase
    end
endmodule

// File: rtl/disp_mutex_bank.sv
// Bank of frame-aligned display locks behind a flat register interface.
// Assumes one-cycle write strobes and single-cycle start-of-frame pulses.
module disp_mutex_bank
    import dmx_pkg::*;
#(
    parameter int NUM_INST = 10,
    parameter int NUM_MOD  = 32,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int NUM_SRC  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] sof_pulse,
    output logic [NUM_MOD-1:0] mod_hold
);
    localparam int IDX_W = $clog2(NUM_INST);

    logic                               dec_hit;
    logic [IDX_W-1:0]                   dec_idx;
    reg_sel_e                           dec_sel;
    logic [NUM_INST-1:0]                inst_en;
    logic [NUM_INST-1:0]                inst_pend;
    logic [NUM_INST-1:0]                inst_grant;
    logic [NUM_INST-1:0]                inst_hold;
    logic [NUM_INST-1:0][NUM_MOD-1:0]   mask_arr;
    logic [NUM_INST-1:0][SRC_W-1:0]     src_arr;
    logic [NUM_INST-1:0][DATA_W-1:0]    rd_arr;

    dmx_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_INST (NUM_INST)
    ) u_dec (
        .addr (bus_addr),
        .hit  (dec_hit),
        .idx  (dec_idx),
        .sel  (dec_sel)
    );

    for (genvar i = 0; i < NUM_INST; i++) begin : g_slot
        logic slot_wr;

        // Route the write strobe to the addressed slot only
        always_comb slot_wr = bus_wr && dec_hit && (dec_idx == IDX_W'(i));

        dmx_slot #(
            .DATA_W  (DATA_W),
            .NUM_MOD (NUM_MOD),
            .NUM_SRC (NUM_SRC)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (slot_wr),
            .sel     (dec_sel),
            .wdata   (bus_wdata),
            .sof_in  (sof_pulse),
            .en      (inst_en[i]),
            .pend    (inst_pend[i]),
            .granted (inst_grant[i]),
            .hold    (inst_hold[i]),
            .mask    (mask_arr[i]),
            .src     (src_arr[i]),
            .rd_word (rd_arr[i])
        );
    end

    // Return the addressed slot's word, zero outside the map
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_INST; i++) begin
            if (dec_hit && (dec_idx == IDX_W'(i))) bus_rdata = rd_arr[i];
        end
    end

    // Merge the member masks of every holding slot
    always_comb begin
        mod_hold = '0;
        for (int i = 0; i < NUM_INST; i++) begin
            if (inst_hold[i]) mod_hold = mod_hold | mask_arr[i];
        end
    end
endmodule

// File: rtl/dmx_bank_chk.sv
// Checker for the lock bank: grant and hold timing against frame pulses.
// Assumes sof pulses are one cycle wide and sources do not change mid-hold.
module dmx_bank_chk #(
    parameter int NUM_INST = 10,
    parameter int NUM_MOD  = 32,
    parameter int NUM_SRC  = 3
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_SRC-1:0]               sof_pulse,
    input logic [NUM_INST-1:0]              en,
    input logic [NUM_INST-1:0]              pend,
    input logic [NUM_INST-1:0]              grant,
    input logic [NUM_INST-1:0]              hold,
    input logic [NUM_INST-1:0][1:0]         src,
    input logic [NUM_INST-1:0][NUM_MOD-1:0] mask,
    input logic [NUM_MOD-1:0]               mod_hold
);
    logic [NUM_INST-1:0] fire_q;

    // Remember whether each slot's chosen source fired on the last edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_q <= '0;
        end else begin
            for (int i = 0; i < NUM_INST; i++) begin
                case (src[i])
                    2'd0:    fire_q[i] <= 1'b1;
                    2'd1:    fire_q[i] <= sof_pulse[0];
                    2'd2:    fire_q[i] <= sof_pulse[1];
                    default: fire_q[i] <= sof_pulse[2];
                endcase
            end
        end
    end

    for (genvar i = 0; i < NUM_INST; i++) begin : g_chk
        AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant[i]) |-> $past(pend[i]));                          // R3
        AST_GRANT_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant[i]) |-> fire_q[i]);                               // R5
        AST_HOLD_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> hold[i]);                                        // R7
        AST_HOLD_DROP_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(hold[i]) |-> fire_q[i]);                                // R7
        AST_HOLD_REACHES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            hold[i] |-> ((mod_hold & mask[i]) == mask[i]));               // R7
        AST_NO_GRANT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[i] && !grant[i]) |=> !grant[i]);                         // R9
    end
endmodule

bind disp_mutex_bank dmx_bank_chk #(
    .NUM_INST (NUM_INST),
    .NUM_MOD  (NUM_MOD),
    .NUM_SRC  (NUM_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof_pulse (sof_pulse),
    .en        (inst_en),
    .pend      (inst_pend),
    .grant     (inst_grant),
    .hold      (inst_hold),
    .src       (src_arr),
    .mask      (mask_arr),
    .mod_hold  (mod_hold)
);

// File: tb/sim_disp_mutex_bank.sv
module sim_disp_mutex_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  sof_pulse = '0;
    logic [31:0] mod_hold;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    disp_mutex_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sof_pulse (sof_pulse),
        .mod_hold  (mod_hold)
    );

    function automatic logic [11:0] ra(int n, int ofs);
        return 12'(32 + 32 * n + ofs);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pulse(int b);
        @(negedge clk);
        sof_pulse[b] = 1'b1;
        @(negedge clk);
        sof_pulse = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 en0", ra(0, 'h0), 0);
        rd_chk("R1 lock9", ra(9, 'h4), 0);
        rd_chk("R1 mask9", ra(9, 'hC), 0);
        rd_chk("R1 src0", ra(0, 'h10), 0);
        chk("R1 hold", mod_hold, 0);
    endtask

    task automatic t_regs();
        wr(ra(3, 'h0), 1);
        rd_chk("R2 en set", ra(3, 'h0), 1);
        wr(ra(3, 'hC), 32'hA5A5_0F0F);
        rd_chk("R10 mask", ra(3, 'hC), 32'hA5A5_0F0F);
        wr(ra(3, 'h10), 2);
        rd_chk("R1 src", ra(3, 'h10), 2);
        rd_chk("R1 isolate", ra(4, 'hC), 0);
        wr(ra(3, 'h0), 0);
        rd_chk("R2 en clr", ra(3, 'h0), 0);
        wr(ra(3, 'hC), 0);
    endtask

    task automatic t_single();
        wr(ra(0, 'h0), 1);
        wr(ra(0, 'hC), 32'h1);
        wr(ra(0, 'h4), 1);
        rd_chk("R4 not yet", ra(0, 'h4), 32'h1);
        idle(1);
        rd_chk("R3 granted", ra(0, 'h4), 32'h3);
        chk("R7 hold on", mod_hold & 32'h1, 32'h1);
        wr(ra(0, 'h4), 0);
        rd_chk("R6 released", ra(0, 'h4), 0);
        chk("R7 hold lingers", mod_hold & 32'h1, 32'h1);
        idle(1);
        chk("R7 hold off", mod_hold & 32'h1, 0);
    endtask

    task automatic t_sof();
        wr(ra(1, 'h0), 1);
        wr(ra(1, 'hC), 32'h100);
        wr(ra(1, 'h10), 3);
        wr(ra(1, 'h4), 1);
        idle(3);
        rd_chk("R5 waits", ra(1, 'h4), 32'h1);
        pulse(0);
        rd_chk("R5 other src", ra(1, 'h4), 32'h1);
        pulse(2);
        rd_chk("R5 granted", ra(1, 'h4), 32'h3);
        chk("R7 hold sof", mod_hold & 32'h100, 32'h100);
        wr(ra(1, 'h4), 0);
        rd_chk("R6 release sof", ra(1, 'h4), 0);
        idle(3);
        chk("R7 hold waits", mod_hold & 32'h100, 32'h100);
        pulse(2);
        chk("R7 hold drops", mod_hold & 32'h100, 0);
        wr(ra(2, 'h0), 1);
        wr(ra(2, 'h10), 2);
        wr(ra(2, 'h4), 1);
        pulse(1);
        rd_chk("R5 src2", ra(2, 'h4), 32'h3);
        wr(ra(2, 'h4), 0);
        pulse(1);
    endtask

    task automatic t_clear();
        wr(ra(1, 'h4), 1);
        pulse(2);
        rd_chk("R8 pre", ra(1, 'h4), 32'h3);
        wr(ra(1, 'h8), 1);
        rd_chk("R8 lock gone", ra(1, 'h4), 0);
        rd_chk("R8 en kept", ra(1, 'h0), 1);
        rd_chk("R8 mask kept", ra(1, 'hC), 32'h100);
        rd_chk("R8 src kept", ra(1, 'h10), 3);
        wr(ra(1, 'h4), 1);
        wr(ra(1, 'h8), 1);
        pulse(2);
        rd_chk("R8 pend gone", ra(1, 'h4), 0);
    endtask

    task automatic t_disabled();
        wr(ra(5, 'hC), 32'h2);
        wr(ra(5, 'h4), 1);
        idle(3);
        rd_chk("R9 status", ra(5, 'h4), 0);
        chk("R9 no hold", mod_hold & 32'h2, 0);
    endtask

    task automatic t_unmapped();
        wr(12'h000, 32'hFFFF_FFFF);
        wr(ra(6, 'h14), 32'hFFFF_FFFF);
        wr(ra(6, 'h1C), 32'hFFFF_FFFF);
        wr(ra(6, 'h2), 32'hFFFF_FFFF);
        wr(12'h160, 32'hFFFF_FFFF);
        rd_chk("R11 low", 12'h000, 0);
        rd_chk("R11 gap", ra(6, 'h14), 0);
        rd_chk("R11 misalign", ra(6, 'h2), 0);
        rd_chk("R11 beyond", 12'h160, 0);
        rd_chk("R11 clear reg", ra(1, 'h8), 0);
        rd_chk("R11 en6", ra(6, 'h0), 0);
        rd_chk("R11 mask6", ra(6, 'hC), 0);
        rd_chk("R11 src6", ra(6, 'h10), 0);
        chk("R11 hold", mod_hold, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_single();
        t_sof();
        t_clear();
        t_disabled();
        t_unmapped();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule